// File: doc/BRIEF.md
# Multi-Mode Byte Code Converter

This block turns one 8-bit code word into another under control of a 3-bit mode select. Eight fixed conversions share the same input byte. They cover Gray coding in both directions, packed BCD to and from binary, two's complement negation, hexadecimal and decimal character display, and a raw character mode that passes a segment pattern straight through.

In the two character modes the block also drives two seven-segment digits for a common-cathode display. The low digit is the units place and comes from the converted result. The high digit, the tens place in decimal or the sixteens place in hex, is decoded directly from the upper nibble of the input word. That nibble is decoded one-hot and then encoded to segments.

Every output is registered under a clock enable. A result appears one clock edge after the edge that samples the select and the input with the enable high.

Top module: `ccv_code_converter`

## Requirements
- R1: While `rst_n` is low, every output is zero: `dout`, `seg_lo`, `seg_hi`, `range_err` and `bcd_err`.
- R2: The outputs change only on a rising edge at which `en` is high. On an edge with `en` low, all outputs keep their values whatever `sel` and `din` are.
- R3: With `sel`=000, `dout` is the Gray code of `din`, computed as `din ^ (din >> 1)`.
- R4: With `sel`=100, `din` is read as Gray code. `dout` bit 7 equals `din` bit 7, and each lower `dout` bit i is `dout[i+1] ^ din[i]`.
- R5: With `sel`=011 and `din` in the range 0..99, `dout` is packed BCD, with the tens in bits 7..4 and the units in bits 3..0. For `din` of 100 or more, `dout` is 8'hFF and `range_err` is 1.
- R6: With `sel`=101 and both nibbles of `din` in the range 0..9, `dout` is the binary value 10*`din[7:4]` + `din[3:0]`.
- R7: With `sel`=001 or 101, if either nibble of `din` is above 9, then `bcd_err` is 1 and `dout`, `seg_lo` and `seg_hi` are all zero.
- R8: With `sel`=001 and a valid BCD input, `dout` is `{4'h0, din[3:0]}`. `seg_lo` shows `din[3:0]` with the decimal point off, and `seg_hi` shows `din[7:4]`.
- R9: With `sel`=010, `dout` is `{4'h0, din[3:0]}`. `seg_lo` shows the hex character of `din[3:0]` with the decimal point off, and `seg_hi` shows the hex character of `din[7:4]`.
- R10: With `sel`=110, `dout` is the two's complement of `din`, modulo 256.
- R11: With `sel`=111, `dout` equals `din`, `seg_lo` equals `din` (bit 7 is the decimal point and bits 6..0 are segments g..a), and `seg_hi` is zero.
- R12: Segment bit 0 is a and bit 6 is g, and a segment is lit when its bit is 1. The patterns for 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R13: In modes 000, 011, 100, 101 and 110, `seg_lo` and `seg_hi` are zero. `range_err` is 1 only in mode 011, and `bcd_err` is 1 only in modes 001 and 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the output registers |
| sel | input | 3 | Conversion mode select |
| din | input | 8 | Input code word |
| dout | output | 8 | Converted byte |
| seg_lo | output | 8 | Units digit: bit 7 is the decimal point, bits 6..0 are segments g..a |
| seg_hi | output | 7 | Tens or sixteens digit, segments g..a |
| range_err | output | 1 | Binary-to-BCD input above 99 |
| bcd_err | output | 1 | BCD input nibble above 9 |

## Verification
Every result is due at the first rising edge at which `en` is high, and it then holds through any edges with `en` low. Reset clears the outputs asynchronously, with no edge needed. The bench changes `sel`, `din` and `en` on the falling edge. Its behavioural model updates only on rising edges that have `en` high, and the bench compares the outputs at the next falling edge, so each check samples exactly one register stage after its stimulus. Reset is checked a short delay after `rst_n` falls.

// File: rtl/ccv_pkg.sv
package ccv_pkg;

   typedef enum logic [2:0] {
      MODE_BIN2GRAY = 3'b000,
      MODE_BCD2DEC  = 3'b001,
      MODE_BIN2HEX  = 3'b010,
      MODE_BIN2BCD  = 3'b011,
      MODE_GRAY2BIN = 3'b100,
      MODE_BCD2BIN  = 3'b101,
      MODE_NEGATE   = 3'b110,
      MODE_RAWCHAR  = 3'b111
   } ccv_mode_e;

   // segment order g..a, lit = 1
   function automatic logic [6:0] seg_pattern(input logic [3:0] v);
      case (v)
         4'h0: seg_pattern = 7'h3F;
         4'h1: seg_pattern = 7'h06;
         4'h2: seg_pattern = 7'h5B;
         4'h3: seg_pattern = 7'h4F;
         4'h4: seg_pattern = 7'h66;
         4'h5: seg_pattern = 7'h6D;
         4'h6: seg_pattern = 7'h7D;
         4'h7: seg_pattern = 7'h07;
         4'h8: seg_pattern = 7'h7F;
         4'h9: seg_pattern = 7'h6F;
         4'hA: seg_pattern = 7'h77;
         4'hB: seg_pattern = 7'h7C;
         4'hC: seg_pattern = 7'h39;
         4'hD: seg_pattern = 7'h5E;
         4'hE: seg_pattern = 7'h79;
         default: seg_pattern = 7'h71;
      endcase
   endfunction

endpackage

// File: rtl/ccv_nib_decode.sv
module ccv_nib_decode #(
   parameter int NIB_W = 4,
   localparam int LINES = 2 ** NIB_W
) (
   input  logic [NIB_W-1:0] nib,
   output logic [LINES-1:0] hot
);
   generate
      if (NIB_W < 1 || NIB_W > 4) begin : g_bad_width
         $error("ccv_nib_decode: NIB_W must be 1..4");
      end
      for (genvar i = 0; i < LINES; i++) begin : g_line
         assign hot[i] = (nib == NIB_W'(i));
      end
   endgenerate
endmodule

// File: rtl/ccv_seg_encode.sv
module ccv_seg_encode
   import ccv_pkg::*;
#(
   parameter int NIB_W = 4,
   parameter int SEG_W = 7,
   localparam int LINES = 2 ** NIB_W
) (
   input  logic [LINES-1:0] hot,
   output logic [SEG_W-1:0] seg
);
   logic [SEG_W-1:0] term [LINES];

   generate
      if (NIB_W != 4 || SEG_W != 7) begin : g_bad_shape
         $error("ccv_seg_encode: only a 16-line, 7-segment matrix is defined");
      end
      for (genvar d = 0; d < LINES; d++) begin : g_row
         assign term[d] = hot[d] ? SEG_W'(seg_pattern(4'(d))) : '0;
      end
   endgenerate

   always_comb begin
      seg = '0;
      for (int d = 0; d < LINES; d++) seg = seg | term[d];
   end
endmodule

// File: rtl/ccv_conv_core.sv
module ccv_conv_core
   import ccv_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int NIB_W = DATA_W / 2,
   localparam int BCD_LIMIT = 100,
   localparam int DIGIT_MAX = 9
) (
   input  ccv_mode_e         mode,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] res,
   output logic              char_mode,
   output logic              raw_mode,
   output logic              range_err,
   output logic              bcd_err
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("ccv_conv_core: conversions are defined for an 8-bit word");
      end
   endgenerate

   logic [NIB_W-1:0]  hi_nib, lo_nib;
   logic              bcd_ok, in_range;
   logic [DATA_W-1:0] gray2bin, bcd_value, bin_bcd;

   assign hi_nib   = din[DATA_W-1:NIB_W];
   assign lo_nib   = din[NIB_W-1:0];
   assign bcd_ok   = (hi_nib <= NIB_W'(DIGIT_MAX)) && (lo_nib <= NIB_W'(DIGIT_MAX));
   assign in_range = din < DATA_W'(BCD_LIMIT);

   always_comb begin
      gray2bin[DATA_W-1] = din[DATA_W-1];
      for (int i = DATA_W - 2; i >= 0; i--) gray2bin[i] = gray2bin[i+1] ^ din[i];
   end

   assign bcd_value = DATA_W'(hi_nib) * DATA_W'(10) + DATA_W'(lo_nib);
   assign bin_bcd   = {NIB_W'(din / DATA_W'(10)), NIB_W'(din % DATA_W'(10))};

   always_comb begin
      res       = '0;
      range_err = 1'b0;
      bcd_err   = 1'b0;
      char_mode = 1'b0;
      raw_mode  = 1'b0;
      unique case (mode)
         MODE_BIN2GRAY: res = din ^ (din >> 1);
         MODE_BCD2DEC: begin
            char_mode = 1'b1;
            bcd_err   = !bcd_ok;
            res       = bcd_ok ? DATA_W'(lo_nib) : '0;
         end
         MODE_BIN2HEX: begin
            char_mode = 1'b1;
            res       = DATA_W'(lo_nib);
         end
         MODE_BIN2BCD: begin
            range_err = !in_range;
            res       = in_range ? bin_bcd : '1;
         end
         MODE_GRAY2BIN: res = gray2bin;
         MODE_BCD2BIN: begin
            bcd_err = !bcd_ok;
            res     = bcd_ok ? bcd_value : '0;
         end
         MODE_NEGATE: res = ~din + DATA_W'(1);
         MODE_RAWCHAR: begin
            raw_mode = 1'b1;
            res      = din;
         end
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/ccv_code_converter.sv
module ccv_code_converter
   import ccv_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3,
   parameter int SEG_W  = 7,
   localparam int NIB_W = DATA_W / 2,
   localparam int LINES = 2 ** NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic [SEG_W:0]    seg_lo,
   output logic [SEG_W-1:0]  seg_hi,
   output logic              range_err,
   output logic              bcd_err
);
   generate
      if (SEL_W != 3) begin : g_bad_sel
         $error("ccv_code_converter: SEL_W must be 3");
      end
      if (SEG_W + 1 != DATA_W) begin : g_bad_seg
         $error("ccv_code_converter: raw character byte must fill segments plus point");
      end
   endgenerate

   logic [DATA_W-1:0] res;
   logic              char_mode, raw_mode, rng_d, bcd_d;
   logic [LINES-1:0]  lo_hot, hi_hot;
   logic [SEG_W-1:0]  lo_seg, hi_seg;
   logic [SEG_W:0]    seg_lo_d;
   logic [SEG_W-1:0]  seg_hi_d;

   ccv_conv_core #(.DATA_W(DATA_W)) u_core (
      .mode(ccv_mode_e'(sel)), .din(din), .res(res), .char_mode(char_mode),
      .raw_mode(raw_mode), .range_err(rng_d), .bcd_err(bcd_d)
   );

   ccv_nib_decode #(.NIB_W(NIB_W)) u_lo_dec (.nib(res[NIB_W-1:0]), .hot(lo_hot));
   ccv_nib_decode #(.NIB_W(NIB_W)) u_hi_dec (.nib(din[DATA_W-1:NIB_W]), .hot(hi_hot));

   ccv_seg_encode #(.NIB_W(NIB_W), .SEG_W(SEG_W)) u_lo_enc (.hot(lo_hot), .seg(lo_seg));
   ccv_seg_encode #(.NIB_W(NIB_W), .SEG_W(SEG_W)) u_hi_enc (.hot(hi_hot), .seg(hi_seg));

   always_comb begin
      seg_lo_d = '0;
      seg_hi_d = '0;
      if (raw_mode) begin
         seg_lo_d = din;
      end else if (char_mode && !bcd_d) begin
         seg_lo_d = {1'b0, lo_seg};
         seg_hi_d = hi_seg;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout      <= '0;
         seg_lo    <= '0;
         seg_hi    <= '0;
         range_err <= 1'b0;
         bcd_err   <= 1'b0;
      end else if (en) begin
         dout      <= res;
         seg_lo    <= seg_lo_d;
         seg_hi    <= seg_hi_d;
         range_err <= rng_d;
         bcd_err   <= bcd_d;
      end
   end

   AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(dout) && $stable(seg_lo) && $stable(seg_hi)
               && $stable(range_err) && $stable(bcd_err))); // R2
   AST_HIGH_DIGIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hi_hot) == 1); // R12
   AST_RANGE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      range_err |-> (dout == '1 && !bcd_err)); // R5
   AST_BCD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      bcd_err |-> (dout == '0 && seg_lo == '0 && seg_hi == '0)); // R7
   AST_NONCHAR_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (sel == MODE_BIN2GRAY || sel == MODE_BIN2BCD || sel == MODE_GRAY2BIN
              || sel == MODE_BCD2BIN || sel == MODE_NEGATE))
      |=> (seg_lo == '0 && seg_hi == '0)); // R13
   AST_RANGE_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (en && sel != MODE_BIN2BCD) |=> !range_err); // R13
endmodule

// File: tb/ccv_code_converter_bench.sv
module ccv_code_converter_bench;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [2:0] sel = '0;
   logic [7:0] din = '0;
   logic [7:0] dout, seg_lo;
   logic [6:0] seg_hi;
   logic       range_err, bcd_err;

   int checks = 0;
   int fails  = 0;

   // model state
   int m_dout = 0, m_lo = 0, m_hi = 0, m_rng = 0, m_bcd = 0;

   always #(CLK_P/2) clk = ~clk;

   ccv_code_converter u_ccv_code_converter (
      .clk(clk), .rst_n(rst_n), .en(en), .sel(sel), .din(din), .dout(dout),
      .seg_lo(seg_lo), .seg_hi(seg_hi), .range_err(range_err), .bcd_err(bcd_err)
   );

   function automatic int seg7(input int v);
      int t[16] = '{'h3F, 'h06, 'h5B, 'h4F, 'h66, 'h6D, 'h7D, 'h07,
                    'h7F, 'h6F, 'h77, 'h7C, 'h39, 'h5E, 'h79, 'h71};
      return t[v];
   endfunction

   task automatic model(input int s, input int d);
      int hi = d / 16, lo = d % 16, acc;
      m_dout = 0; m_lo = 0; m_hi = 0; m_rng = 0; m_bcd = 0;
      case (s)
         0: m_dout = d ^ (d / 2);
         1: if (hi > 9 || lo > 9) m_bcd = 1;
            else begin m_dout = lo; m_lo = seg7(lo); m_hi = seg7(hi); end
         2: begin m_dout = lo; m_lo = seg7(lo); m_hi = seg7(hi); end
         3: if (d > 99) begin m_dout = 255; m_rng = 1; end
            else m_dout = (d / 10) * 16 + d % 10;
         4: begin
            acc = 0;
            for (int b = 7; b >= 0; b--) begin
               acc = ((acc / 2) % 2) ^ ((d >> b) & 1) ? acc | 1 : acc & ~1;
               if (b == 7) acc = (d >> 7) & 1;
               m_dout = m_dout | (acc << b);
               acc = acc * 2;
            end
         end
         5: if (hi > 9 || lo > 9) m_bcd = 1; else m_dout = hi * 10 + lo;
         6: m_dout = (256 - d) % 256;
         default: begin m_dout = d; m_lo = d; end
      endcase
   endtask

   task automatic check(input string tag, input int s, input int d);
      checks++;
      if (dout !== 8'(m_dout) || range_err !== 1'(m_rng) || bcd_err !== 1'(m_bcd)) begin
         fails++;
         $display("FAIL %s sel=%0d din=%02h: dout=%02h rng=%0b bcd=%0b expected dout=%02h rng=%0d bcd=%0d",
                  tag, s, d, dout, range_err, bcd_err, m_dout, m_rng, m_bcd);
      end
      checks++;
      if (seg_lo !== 8'(m_lo) || seg_hi !== 7'(m_hi)) begin
         fails++;
         $display("FAIL %s sel=%0d din=%02h: seg_lo=%02h seg_hi=%02h expected seg_lo=%02h seg_hi=%02h",
                  tag, s, d, seg_lo, seg_hi, m_lo, m_hi);
      end
   endtask

   function automatic string mode_tag(input int s, input int d);
      if ((s == 1 || s == 5) && ((d / 16) > 9 || (d % 16) > 9)) return "R7";
      case (s)
         0: return "R3";
         1: return "R8/R12";
         2: return "R9/R12";
         3: return "R5/R13";
         4: return "R4/R13";
         5: return "R6/R13";
         6: return "R10/R13";
         default: return "R11";
      endcase
   endfunction

   task automatic step(input logic e, input int s, input int d, input string tag);
      en = e; sel = 3'(s); din = 8'(d);
      @(posedge clk);
      if (e) model(s, d);
      @(negedge clk);
      check(tag, s, d);
   endtask

   task automatic pulse_reset();
      rst_n = 1'b0;
      #1;
      m_dout = 0; m_lo = 0; m_hi = 0; m_rng = 0; m_bcd = 0;
      check("R1", -1, 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_P * 200000);
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      check("R1", -1, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      step(1, 3, 99, "R5");
      step(1, 3, 100, "R5");
      step(1, 5, 8'h99, "R6");
      step(1, 5, 8'h3A, "R7");
      step(1, 1, 8'hA3, "R7");
      step(1, 1, 8'h47, "R8");
      step(1, 2, 8'hF0, "R9");
      step(1, 6, 0, "R10");
      step(1, 6, 8'h80, "R10");
      step(1, 7, 8'hFF, "R11");
      step(1, 4, 8'h80, "R4");
      step(1, 0, 8'hFF, "R3");

      // hold with enable low
      step(1, 2, 8'h5C, "R9");
      step(0, 6, 8'h13, "R2");
      step(0, 1, 8'hAA, "R2");
      step(0, 3, 8'hFF, "R2");
      step(1, 3, 8'hFF, "R5");
      step(0, 2, 8'h21, "R2");

      // full sweep of every mode, with idle edges mixed in
      for (int s = 0; s < 8; s++) begin
         for (int d = 0; d < 256; d++) begin
            step(1, s, d, mode_tag(s, d));
            if (d % 37 == 5) step(0, (s + 3) % 8, 255 - d, "R2");
         end
      end

      // reset in the middle of a run
      step(1, 3, 150, "R5");
      pulse_reset();
      step(1, 1, 8'h95, "R8");
      summary();
   end
endmodule